// File: doc/BRIEF.md
# Control Indicator Repeat Modifier

This block sits in the repeat path of a token-ring-style media access controller. After a frame's ending delimiter, the ring carries a short run of control indicator symbols. Each indicator is either a Reset (R) or a Set (S) symbol. The block passes the whole symbol stream through with one register stage. It can rewrite the fourth and/or the fifth indicator of each run so that an S goes out on the ring whatever was received.

An enable input exists for each of the two positions. When a forced position receives an indicator that is already S, the block raises a one-cycle interrupt for that position. The pulse comes out in the same cycle as the affected output symbol. The upstream logic marks the indicator part of the stream with a phase flag. Symbol decoding and the meaning of frame status are handled elsewhere.

Top module: `cirm_top`

## Requirements
- R1: Every symbol accepted while `in_valid` is high appears on `out_sym` exactly one clock later, with `out_valid` high. `out_valid` is low one clock after any cycle in which `in_valid` was low.
- R2: While `force_pos4` is 0, the fourth indicator of a run is sent unchanged.
- R3: While `force_pos4` is 1, the fourth indicator of a run is sent as the S code (4'h2), whether it arrived as R or S.
- R4: `irq_pos4` pulses for exactly one cycle, together with the output symbol, when `force_pos4` is 1 and the fourth indicator arrived as S. It is low at all other times.
- R5: `force_pos5` acts on the fifth indicator in the same way, and `irq_pos5` acts as its own separate interrupt under the same rules as R3 and R4.
- R6: A run with fewer indicators than a forced position is sent without modification, and that position's interrupt is not raised.
- R7: Indicators are counted from 1, starting at the first R (4'h1) or S (4'h2) symbol accepted with `in_ind_phase` high. Any other code accepted with `in_ind_phase` high ends counting until the phase flag drops. Later R or S symbols in the same run are not counted and are not modified.
- R8: Symbols accepted with `in_ind_phase` low, and indicators at positions other than four and five, are sent unchanged, even when their code equals R or S. An accepted symbol with `in_ind_phase` low restarts the count for the next run.
- R9: While `rst` is high, and in the first cycle after it, `out_valid`, `irq_pos4` and `irq_pos5` are low.
- R10: Cycles with `in_valid` low do not advance or restart the indicator count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input symbol is present this cycle |
| in_sym | input | 4 | Received symbol code |
| in_ind_phase | input | 1 | High while the stream is in the control indicator part of a frame |
| force_pos4 | input | 1 | Send the fourth indicator as S |
| force_pos5 | input | 1 | Send the fifth indicator as S |
| out_valid | output | 1 | Output symbol is present |
| out_sym | output | 4 | Repeated, possibly rewritten, symbol |
| irq_pos4 | output | 1 | Fourth indicator was forced and had already arrived as S |
| irq_pos5 | output | 1 | Fifth indicator was forced and had already arrived as S |

## Verification
The stimulus covers indicator runs of six and more symbols under each combination of the two enables, with R or S at positions four and five. These runs show whether the rewrite hits the right position and whether the interrupt tells an existing S apart from a rewritten R. Runs of three and four indicators check that nothing is forced past the end of a run. A run cut short by a foreign code checks that counting stops, and gaps inside a run check that idle cycles do not shift the position. Frames sent back to back, data symbols that reuse the R and S codes, and a long random stream check that the count restarts and that data outside the indicator phase is left alone.

// File: rtl/cirm_pkg.sv
package cirm_pkg;

    localparam int SYM_W    = 4;
    localparam int LANES    = 2;
    localparam int BASE_POS = 4;

    typedef logic [SYM_W-1:0] sym_t;

    localparam sym_t CODE_R = sym_t'(1);
    localparam sym_t CODE_S = sym_t'(2);

    typedef enum logic [1:0] {
        CI_NONE  = 2'd0,
        CI_RESET = 2'd1,
        CI_SET   = 2'd2
    } ci_kind_e;

    typedef struct packed {
        logic valid;
        logic phase;
        sym_t sym;
    } beat_t;

    typedef struct packed {
        logic             valid;
        sym_t             sym;
        logic [LANES-1:0] irq;
    } out_beat_t;

    function automatic ci_kind_e classify(input sym_t s);
        if (s == CODE_R)      return CI_RESET;
        else if (s == CODE_S) return CI_SET;
        else                  return CI_NONE;
    endfunction

endpackage

// File: rtl/cirm_classify.sv
module cirm_classify
    import cirm_pkg::*;
(
    input  beat_t    beat,
    output ci_kind_e kind,
    output logic     is_ind,
    output logic     is_foreign
);
    always_comb begin
        kind       = classify(beat.sym);
        is_ind     = beat.valid && beat.phase && (kind != CI_NONE);
        is_foreign = beat.valid && beat.phase && (kind == CI_NONE);
    end
endmodule

// File: rtl/cirm_tracker.sv
module cirm_tracker
    import cirm_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  beat_t            beat,
    input  logic             is_ind,
    input  logic             is_foreign,
    output logic [CNT_W-1:0] pos
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;
    logic             halted_q;
    logic [CNT_W-1:0] cnt_inc;

    always_comb begin
        cnt_inc = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
        pos     = (is_ind && !halted_q) ? cnt_inc : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            halted_q <= 1'b0;
        end else if (beat.valid) begin
            if (!beat.phase) begin
                cnt_q    <= '0;
                halted_q <= 1'b0;
            end else if (!halted_q) begin
                if (is_ind)
                    cnt_q <= cnt_inc;
                else if (is_foreign)
                    halted_q <= 1'b1;
            end
        end
    end

    // R7: once a foreign code ends the run, no position is reported
    a_r7_halted_no_pos: assert property (@(posedge clk) disable iff (rst)
        (halted_q && beat.valid && beat.phase) |-> (pos == '0));

    // R10: idle cycles leave the tracker state untouched
    a_r10_idle_holds: assert property (@(posedge clk) disable iff (rst)
        (!beat.valid) |=> ($stable(cnt_q) && $stable(halted_q)));

    // R8: a symbol outside the indicator phase restarts the count
    a_r8_phase_restarts: assert property (@(posedge clk) disable iff (rst)
        (beat.valid && !beat.phase) |=> (cnt_q == '0 && !halted_q));
endmodule

// File: rtl/cirm_force_lane.sv
module cirm_force_lane
    import cirm_pkg::*;
#(
    parameter int CNT_W  = 3,
    parameter int TARGET = 4
) (
    input  logic             en,
    input  logic [CNT_W-1:0] pos,
    input  ci_kind_e         kind,
    output logic             force_s,
    output logic             irq_hit
);
    localparam logic [CNT_W-1:0] TARGET_POS = CNT_W'(TARGET);

    always_comb begin
        force_s = en && (pos == TARGET_POS);
        irq_hit = force_s && (kind == CI_SET);
    end
endmodule

// File: rtl/cirm_top.sv
module cirm_top
    import cirm_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [SYM_W-1:0] in_sym,
    input  logic             in_ind_phase,
    input  logic             force_pos4,
    input  logic             force_pos5,
    output logic             out_valid,
    output logic [SYM_W-1:0] out_sym,
    output logic             irq_pos4,
    output logic             irq_pos5
);
    beat_t            beat;
    ci_kind_e         kind;
    logic             is_ind;
    logic             is_foreign;
    logic [CNT_W-1:0] pos;
    logic [LANES-1:0] lane_en;
    logic [LANES-1:0] lane_force;
    logic [LANES-1:0] lane_irq;
    out_beat_t        nxt;
    out_beat_t        out_q;

    always_comb begin
        beat.valid = in_valid;
        beat.phase = in_ind_phase;
        beat.sym   = in_sym;
        lane_en    = {force_pos5, force_pos4};
    end

    cirm_classify u_classify (
        .beat       (beat),
        .kind       (kind),
        .is_ind     (is_ind),
        .is_foreign (is_foreign)
    );

    cirm_tracker #(.CNT_W(CNT_W)) u_tracker (
        .clk        (clk),
        .rst        (rst),
        .beat       (beat),
        .is_ind     (is_ind),
        .is_foreign (is_foreign),
        .pos        (pos)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        cirm_force_lane #(.CNT_W(CNT_W), .TARGET(BASE_POS + g)) u_lane (
            .en      (lane_en[g]),
            .pos     (pos),
            .kind    (kind),
            .force_s (lane_force[g]),
            .irq_hit (lane_irq[g])
        );
    end

    always_comb begin
        nxt.valid = in_valid;
        nxt.sym   = (|lane_force) ? CODE_S : in_sym;
        nxt.irq   = lane_irq;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q.valid <= 1'b0;
            out_q.irq   <= '0;
            out_q.sym   <= '0;
        end else begin
            out_q <= nxt;
        end
    end

    assign out_valid = out_q.valid;
    assign out_sym   = out_q.sym;
    assign irq_pos4  = out_q.irq[0];
    assign irq_pos5  = out_q.irq[1];

    // R1: one-cycle latency of the valid qualifier
    a_r1_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r1_gap_follows: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R3 / R5: a forced position leaves as S
    a_r3_forced_is_s: assert property (@(posedge clk) disable iff (rst)
        (|lane_force) |=> (out_sym == CODE_S));

    // R8: anything not forced is repeated unchanged
    a_r8_unforced_passes: assert property (@(posedge clk) disable iff (rst)
        (in_valid && lane_force == '0) |=> (out_sym == $past(in_sym)));

    // R4: fourth-position interrupt needs the enable and an S output
    a_r4_irq4_cause: assert property (@(posedge clk) disable iff (rst)
        irq_pos4 |-> (out_valid && out_sym == CODE_S && $past(force_pos4)
                      && $past(in_sym) == CODE_S));
    a_r4_irq4_pulse: assert property (@(posedge clk) disable iff (rst)
        irq_pos4 |=> !irq_pos4);

    // R5: fifth-position interrupt, same rules
    a_r5_irq5_cause: assert property (@(posedge clk) disable iff (rst)
        irq_pos5 |-> (out_valid && out_sym == CODE_S && $past(force_pos5)
                      && $past(in_sym) == CODE_S));
    a_r5_irq5_pulse: assert property (@(posedge clk) disable iff (rst)
        irq_pos5 |=> !irq_pos5);

    // R5: the two positions never coincide
    a_r5_irq_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({irq_pos4, irq_pos5}));
endmodule

// File: tb/tb_cirm_top.sv
module tb_cirm_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [3:0] SR = 4'h1;
    localparam logic [3:0] SS = 4'h2;
    localparam logic [3:0] ED = 4'hD;

    typedef struct packed {
        logic [3:0] sym;
        logic       irq4;
        logic       irq5;
        logic [3:0] req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [3:0] in_sym = '0;
    logic       in_ind_phase = 1'b0;
    logic       force_pos4 = 1'b0;
    logic       force_pos5 = 1'b0;
    logic       out_valid;
    logic [3:0] out_sym;
    logic       irq_pos4;
    logic       irq_pos5;

    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    exp_t sb[$];

    // bench model state
    int   m_cnt = 0;
    bit   m_halt = 1'b0;
    bit   m_f4 = 1'b0;
    bit   m_f5 = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cirm_top dut (
        .clk          (clk),
        .rst          (rst),
        .in_valid     (in_valid),
        .in_sym       (in_sym),
        .in_ind_phase (in_ind_phase),
        .force_pos4   (force_pos4),
        .force_pos5   (force_pos5),
        .out_valid    (out_valid),
        .out_sym      (out_sym),
        .irq_pos4     (irq_pos4),
        .irq_pos5     (irq_pos5)
    );

    function automatic string rname(input logic [3:0] r);
        case (r)
            4'd1:    return "R1";
            4'd2:    return "R2";
            4'd3:    return "R3";
            4'd4:    return "R4";
            4'd5:    return "R5";
            4'd6:    return "R6";
            4'd7:    return "R7";
            4'd9:    return "R9";
            4'd10:   return "R10";
            default: return "R8";
        endcase
    endfunction

    task automatic fail_line(input string req, input string what,
                             input int act, input int exp);
        errors++;
        $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    endtask

    // driver: one accepted symbol, expected result pushed to the scoreboard
    task automatic drive(input logic [3:0] s, input logic ph, input logic [3:0] tag);
        exp_t e;
        @(posedge clk);
        #1;
        in_valid     = 1'b1;
        in_sym       = s;
        in_ind_phase = ph;
        force_pos4   = m_f4;
        force_pos5   = m_f5;
        e.sym  = s;
        e.irq4 = 1'b0;
        e.irq5 = 1'b0;
        e.req  = tag;
        if (!ph) begin
            m_cnt  = 0;
            m_halt = 1'b0;
        end else if (!m_halt) begin
            if (s == SR || s == SS) begin
                m_cnt++;
                if (m_cnt == 4 && m_f4) begin
                    e.sym = SS; e.irq4 = (s == SS); e.req = (s == SS) ? 4'd4 : 4'd3;
                end
                if (m_cnt == 5 && m_f5) begin
                    e.sym = SS; e.irq5 = (s == SS); e.req = 4'd5;
                end
            end else begin
                m_halt = 1'b1;
            end
        end
        sb.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
            in_valid     = 1'b0;
            in_sym       = 4'($urandom_range(0, 15));
            in_ind_phase = 1'($urandom_range(0, 1));
            force_pos4   = m_f4;
            force_pos5   = m_f5;
        end
    endtask

    // a frame: some data (phase low), ending delimiter, then indicators
    task automatic frame(input logic [3:0] ind[], input logic [3:0] tag);
        drive(SR, 1'b0, 4'd8);   // data that reuses the R code
        drive(SS, 1'b0, 4'd8);   // data that reuses the S code
        drive(4'h9, 1'b0, 4'd8);
        drive(ED, 1'b0, 4'd8);
        foreach (ind[i]) drive(ind[i], 1'b1, tag);
    endtask

    // monitor: compares output to the scoreboard away from the clock edge
    always @(negedge clk) begin
        if (rst) begin
            checks++;
            if (out_valid !== 1'b0 || irq_pos4 !== 1'b0 || irq_pos5 !== 1'b0)
                fail_line("R9", "reset outputs", {out_valid, irq_pos4, irq_pos5}, 0);
        end else if (out_valid === 1'b1) begin
            checks++;
            if (sb.size() == 0) begin
                fail_line("R1", "unexpected out_valid", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (out_sym !== e.sym)
                    fail_line(rname(e.req), "out_sym", out_sym, e.sym);
                if (irq_pos4 !== e.irq4)
                    fail_line(e.irq4 ? "R4" : rname(e.req), "irq_pos4", irq_pos4, e.irq4);
                if (irq_pos5 !== e.irq5)
                    fail_line(e.irq5 ? "R5" : rname(e.req), "irq_pos5", irq_pos5, e.irq5);
            end
        end else begin
            checks++;
            if (irq_pos4 !== 1'b0 || irq_pos5 !== 1'b0)
                fail_line("R4", "interrupt without output", {irq_pos4, irq_pos5}, 0);
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        // first cycle after reset must still be quiet (R9)
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0)
            fail_line("R9", "out_valid after reset", out_valid, 0);

        // R2 / R8: no enables, six indicators pass unchanged
        m_f4 = 0; m_f5 = 0;
        frame('{SR, SS, SR, SS, SS, SR}, 4'd2);
        idle(2);

        // R3: fourth arrives as R and leaves as S, no interrupt
        m_f4 = 1; m_f5 = 0;
        frame('{SS, SR, SR, SR, SR, SS}, 4'd3);

        // R4: fourth arrives as S, interrupt pulse
        frame('{SR, SR, SR, SS, SR, SR}, 4'd4);

        // R5: both enabled, fourth R forced, fifth already S
        m_f4 = 1; m_f5 = 1;
        frame('{SR, SR, SR, SR, SS, SR, SR}, 4'd5);
        // R5 alone: fifth R forced, fourth untouched
        m_f4 = 0; m_f5 = 1;
        frame('{SR, SR, SR, SS, SR}, 4'd5);

        // R6: short runs with both enables
        m_f4 = 1; m_f5 = 1;
        frame('{SS, SS, SS}, 4'd6);
        frame('{SR, SR, SR, SS}, 4'd6);

        // R7: a foreign code stops counting
        frame('{SR, SR, 4'h7, SS, SS, SS, SR}, 4'd7);
        frame('{SS, SS, SS, 4'h0, SS, SS}, 4'd7);

        // R10: idle gaps inside a run do not move the position
        drive(ED, 1'b0, 4'd8);
        drive(SR, 1'b1, 4'd10);
        idle(2);
        drive(SR, 1'b1, 4'd10);
        drive(SS, 1'b1, 4'd10);
        idle(3);
        drive(SS, 1'b1, 4'd10);
        idle(1);
        drive(SS, 1'b1, 4'd10);
        drive(SR, 1'b1, 4'd10);

        // R8: long run, positions past five and saturation
        frame('{SR, SR, SR, SR, SR, SR, SS, SS, SR, SR, SS}, 4'd8);

        // R8: back-to-back frames restart the count
        frame('{SR, SR}, 4'd8);
        frame('{SR, SR, SS, SS, SS}, 4'd8);

        // random stream
        for (int i = 0; i < 400; i++) begin
            if ($urandom_range(0, 49) == 0) begin
                m_f4 = 1'($urandom_range(0, 1));
                m_f5 = 1'($urandom_range(0, 1));
            end
            if ($urandom_range(0, 5) == 0) idle(1);
            else if ($urandom_range(0, 2) == 0)
                drive(4'($urandom_range(0, 15)), 1'b0, 4'd8);
            else
                drive(($urandom_range(0, 12) == 0) ? 4'h5 :
                      (($urandom_range(0, 1) == 0) ? SR : SS), 1'b1, 4'd8);
        end

        idle(4);
        // R1: every driven symbol produced an output
        checks++;
        if (sb.size() != 0)
            fail_line("R1", "outputs missing", 0, sb.size());
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fail_line("R1", "watchdog expired", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule